// File: doc/BRIEF.md
# Four-Lane 5x5 Convolution Engine

This block filters a two-dimensional array of signed 16-bit samples with a 5x5 weight mask. It reads the array from a linear memory in which every address holds four packed samples. It produces four horizontally adjacent results at a time. Four multiply-accumulate lanes share one buffered window of five rows by eight samples. Each cycle all four lanes multiply by the same weight, and each lane takes its sample from a column offset equal to its own lane number. Walking the weights in order then sweeps every lane across its own 5x5 neighbourhood.

Software first writes the 25 weights through the coefficient port. It then sets the image width and height and pulses the start input. The engine issues one read at a time and waits for each response, so it tolerates any memory latency. After the window is filled, it runs 25 accumulate cycles and then streams the four results out on consecutive cycles. When it moves to the next group in the same row, it keeps the right half of the window and fetches only the five new words.

A control state machine sequences the work. Its states are IDLE, REQ (drive one read request), WAIT (hold until the response arrives), MAC (25 accumulate steps) and EMIT (four result cycles). The transitions are:
- IDLE to REQ on start.
- REQ to WAIT, always.
- WAIT back to REQ when a response arrives and the window is still incomplete.
- WAIT to MAC when the final response of the group arrives.
- MAC to EMIT after step 24.
- EMIT to REQ after the fourth result when more groups remain.
- EMIT to IDLE after the last result of the frame.

Top module: `conv5_engine`

## Requirements
- R1: After reset, and while idle, rd_req, res_valid and done are all low.
- R2: Weight index k = 5*a + b holds the weight for row offset a-2 and column offset b-2. coef_idx selects k, and coef_we stores coef_data there while the engine is idle.
- R3: Sample (r, c) lives at address ADDR_BASE + r*(W/4) + c/4, in bits 16*(c%4)+15 down to 16*(c%4) of rd_data. W is the image width and must be a multiple of 4, at least 8. The height must be at least 5.
- R4: Each result equals the exact signed sum, over a and b from 0 to 4, of weight[5a+b] * D[i+a-2][j+b-2], with no rounding or saturation. Results are produced for i from 2 to H-3 and j from 2 to W-3, in row-major order.
- R5: Each result is marked by one res_valid cycle. Results arrive in bursts of exactly four consecutive valid cycles, covering columns j to j+3.
- R6: At most one read is outstanding. A request lasts one cycle and is never repeated before its response. The first group of an output row takes 10 reads, and every later group in that row takes 5.
- R7: The first result of a group appears on the 26th cycle after the cycle that carries that group's last read response.
- R8: done pulses exactly once per frame, together with the last result.
- R9: A start pulse, or a weight write, that arrives while a frame is in progress has no effect on the results or on the number of results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (ignored when busy) |
| img_w | input | DIM_W | Image width in samples, captured at start |
| img_h | input | DIM_W | Image height in rows, captured at start |
| coef_we | input | 1 | Weight write strobe |
| coef_idx | input | 5 | Weight index 5a+b |
| coef_data | input | 16 | Signed weight value |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 64 | Four packed samples, lowest column in bits 15:0 |
| res_valid | output | 1 | Result strobe |
| res_data | output | ACC_W | Signed full-precision result |
| done | output | 1 | Marks the last result of a frame |

## Verification
The bench keeps the default parameters: 12-bit dimensions, a 24-bit address, base address 1 and a 40-bit accumulator. It sweeps small images of widths 8, 12 and 16 and heights 5 to 8. That covers single-group rows, multi-group rows with window reuse, and several output rows, using both fixed-latency and slower memory responses. Extreme operands (all -32768) drive the sum past 35 bits, which checks that no precision is lost. A unit-impulse mask checks the index mapping for each tap.

// File: rtl/conv5_pkg.sv
package conv5_pkg;
    localparam int LANES    = 4;
    localparam int TAPS     = 5;
    localparam int NCOEF    = TAPS * TAPS;
    localparam int WIN      = 2 * LANES;
    localparam int SAMPLE_W = 16;
    localparam int PROD_W   = 2 * SAMPLE_W;
    localparam int BUS_W    = LANES * SAMPLE_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_MAC,
        S_EMIT
    } conv_state_t;
endpackage

// File: rtl/conv5_coef_rf.sv
module conv5_coef_rf
    import conv5_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [4:0]                 waddr,
    input  logic signed [SAMPLE_W-1:0] wdata,
    input  logic [4:0]                 raddr,
    output logic signed [SAMPLE_W-1:0] rdata
);
    logic signed [SAMPLE_W-1:0] regs_q [NCOEF];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOEF; i++) regs_q[i] <= '0;
        end else if (we && (waddr < 5'(NCOEF))) begin
            regs_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr < 5'(NCOEF)) rdata = regs_q[raddr];
    end
endmodule

// File: rtl/conv5_win_rf.sv
module conv5_win_rf
    import conv5_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_row,
    input  logic                    wr_half,
    input  logic [BUS_W-1:0]        wr_data,
    input  logic                    shift,
    input  logic [2:0]              rd_row,
    output logic [WIN*SAMPLE_W-1:0] row_out
);
    logic [SAMPLE_W-1:0] win_q [TAPS][WIN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < TAPS; r++)
                for (int c = 0; c < WIN; c++) win_q[r][c] <= '0;
        end else if (shift) begin
            for (int r = 0; r < TAPS; r++)
                for (int c = 0; c < LANES; c++) win_q[r][c] <= win_q[r][c+LANES];
        end else if (wr_en && (wr_row < 3'(TAPS))) begin
            for (int n = 0; n < LANES; n++)
                win_q[wr_row][{wr_half, 2'(n)}] <= wr_data[n*SAMPLE_W +: SAMPLE_W];
        end
    end

    always_comb begin
        row_out = '0;
        if (rd_row < 3'(TAPS))
            for (int c = 0; c < WIN; c++) row_out[c*SAMPLE_W +: SAMPLE_W] = win_q[rd_row][c];
    end
endmodule

// File: rtl/conv5_mac_lane.sv
module conv5_mac_lane
    import conv5_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       first,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [SAMPLE_W-1:0] coef,
    output logic signed [ACC_W-1:0]    acc
);
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    assign prod     = sample * coef;
    assign prod_ext = ACC_W'(prod);

    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (en)    acc <= first ? prod_ext : acc + prod_ext;
    end
endmodule

// File: rtl/conv5_engine.sv
module conv5_engine
    import conv5_pkg::*;
#(
    parameter int DIM_W     = 12,
    parameter int ADDR_W    = 24,
    parameter int ADDR_BASE = 1,
    parameter int ACC_W     = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DIM_W-1:0]     img_w,
    input  logic [DIM_W-1:0]     img_h,
    input  logic                 coef_we,
    input  logic [4:0]           coef_idx,
    input  logic [SAMPLE_W-1:0]  coef_data,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic                 rd_valid,
    input  logic [BUS_W-1:0]     rd_data,
    output logic                 res_valid,
    output logic [ACC_W-1:0]     res_data,
    output logic                 done
);
    localparam logic [2:0] LAST_TAP = 3'(TAPS - 1);

    conv_state_t state_q, state_d;

    logic [DIM_W-1:0] w_q, h_q, row_q, grp_q;
    logic [2:0]       fr_q, dr_q, dc_q;
    logic             fh_q;
    logic [1:0]       lane_q;

    logic [DIM_W-1:0] words_per_row;
    logic             last_grp, last_row, fetch_last, mac_last, emit_last;

    assign words_per_row = w_q >> 2;
    assign last_grp      = (grp_q == words_per_row - DIM_W'(2));
    assign last_row      = (row_q == h_q - DIM_W'(3));
    assign fetch_last    = fh_q && (fr_q == LAST_TAP);
    assign mac_last      = (dr_q == LAST_TAP) && (dc_q == LAST_TAP);
    assign emit_last     = (lane_q == 2'(LANES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_REQ;
            S_REQ:  state_d = S_WAIT;
            S_WAIT: if (rd_valid) state_d = fetch_last ? S_MAC : S_REQ;
            S_MAC:  if (mac_last) state_d = S_EMIT;
            S_EMIT: if (emit_last) state_d = (last_grp && last_row) ? S_IDLE : S_REQ;
            default: state_d = S_IDLE;
        endcase
    end

    // sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0; h_q <= '0; row_q <= '0; grp_q <= '0;
            fr_q <= '0; fh_q <= 1'b0; dr_q <= '0; dc_q <= '0; lane_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    w_q   <= img_w;
                    h_q   <= img_h;
                    row_q <= DIM_W'(2);
                    grp_q <= '0;
                    fr_q  <= '0;
                    fh_q  <= 1'b0;
                end
                S_REQ: ;
                S_WAIT: if (rd_valid) begin
                    if (!fh_q) begin
                        fh_q <= 1'b1;
                    end else if (fr_q == LAST_TAP) begin
                        dr_q <= '0;
                        dc_q <= '0;
                    end else begin
                        fr_q <= fr_q + 3'd1;
                        fh_q <= (grp_q != '0);
                    end
                end
                S_MAC: begin
                    if (dc_q == LAST_TAP) begin
                        dc_q <= '0;
                        dr_q <= dr_q + 3'd1;
                    end else begin
                        dc_q <= dc_q + 3'd1;
                    end
                    if (mac_last) lane_q <= '0;
                end
                S_EMIT: begin
                    lane_q <= lane_q + 2'd1;
                    if (emit_last) begin
                        fr_q <= '0;
                        if (last_grp) begin
                            row_q <= row_q + DIM_W'(1);
                            grp_q <= '0;
                            fh_q  <= 1'b0;
                        end else begin
                            grp_q <= grp_q + DIM_W'(1);
                            fh_q  <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // storage and datapath
    logic [4:0]                  coef_raddr;
    logic signed [SAMPLE_W-1:0]  coef_cur;
    logic [WIN*SAMPLE_W-1:0]     win_row;
    logic                        win_wr, win_shift, mac_en, mac_first;
    logic signed [ACC_W-1:0]     acc_w [LANES];

    assign coef_raddr = 5'(dr_q) * 5'd5 + 5'(dc_q);
    assign win_wr     = (state_q == S_WAIT) && rd_valid;
    assign win_shift  = (state_q == S_EMIT) && emit_last && !last_grp;
    assign mac_en     = (state_q == S_MAC);
    assign mac_first  = (dr_q == 3'd0) && (dc_q == 3'd0);

    conv5_coef_rf u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we && (state_q == S_IDLE)),
        .waddr (coef_idx),
        .wdata (coef_data),
        .raddr (coef_raddr),
        .rdata (coef_cur)
    );

    conv5_win_rf u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_wr),
        .wr_row  (fr_q),
        .wr_half (fh_q),
        .wr_data (rd_data),
        .shift   (win_shift),
        .rd_row  (dr_q),
        .row_out (win_row)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [3:0]                 col;
        logic signed [SAMPLE_W-1:0] smp;
        assign col = 4'(L) + 4'(dc_q);
        assign smp = win_row[col*SAMPLE_W +: SAMPLE_W];

        conv5_mac_lane #(.ACC_W(ACC_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (mac_en),
            .first  (mac_first),
            .sample (smp),
            .coef   (coef_cur),
            .acc    (acc_w[L])
        );
    end

    // outputs
    always_comb begin
        rd_req    = (state_q == S_REQ);
        rd_addr   = ADDR_W'(ADDR_BASE)
                  + (ADDR_W'(row_q) - ADDR_W'(2) + ADDR_W'(fr_q)) * ADDR_W'(words_per_row)
                  + ADDR_W'(grp_q) + ADDR_W'(fh_q);
        res_valid = (state_q == S_EMIT);
        res_data  = acc_w[lane_q];
        done      = (state_q == S_EMIT) && emit_last && last_grp && last_row;
    end
endmodule

// File: rtl/conv5_engine_chk.sv
module conv5_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic rd_valid,
    input logic res_valid,
    input logic done
);
    logic [3:0] burst_len;

    always_ff @(posedge clk) begin
        if (!rst_n)         burst_len <= '0;
        else if (res_valid) burst_len <= burst_len + 4'd1;
        else                burst_len <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rd_req && !res_valid && !done));

    // R6
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !res_valid);

    // R5
    burst_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(res_valid) |-> (burst_len == 4'd4));

    // R7
    mac_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(rd_valid, 26));

    // R8
    done_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);
endmodule

bind conv5_engine conv5_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .res_valid (res_valid),
    .done      (done)
);

// File: tb/conv5_engine_bench.sv
`timescale 1ns/1ps
module conv5_engine_bench;
    localparam int DIM_W = 12, ADDR_W = 24, ADDR_BASE = 1, ACC_W = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIM_W-1:0] img_w = '0, img_h = '0;
    logic coef_we = 1'b0;
    logic [4:0] coef_idx = '0;
    logic [15:0] coef_data = '0;
    logic rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic res_valid;
    logic [ACC_W-1:0] res_data;
    logic done;

    always #2.5 clk = ~clk;

    conv5_engine u_conv5_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .img_w(img_w), .img_h(img_h),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .res_valid(res_valid), .res_data(res_data), .done(done)
    );

    int tests = 0, fails = 0;
    int img [0:255];
    int cf [0:24];
    logic [63:0] mem [0:127];
    longint exp_y [0:255];
    int n_exp = 0, res_idx = 0, nreads = 0, ndone = 0;
    int lat = 1;
    int cyc = 0, last_rv = -100, run = 0;
    bit prev_rv = 1'b0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // memory model: one outstanding read, programmable latency
    bit pend = 1'b0;
    int dly = 0;
    logic [ADDR_W-1:0] raddr_q = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; rd_valid <= 1'b0;
        end else if (rd_req) begin
            pend <= 1'b1; dly <= lat - 1; raddr_q <= rd_addr; rd_valid <= 1'b0;
        end else if (pend && dly == 0) begin
            pend <= 1'b0; rd_valid <= 1'b1; rd_data <= mem[raddr_q[6:0]];
        end else begin
            if (pend) dly <= dly - 1;
            rd_valid <= 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
        if (rst_n) begin
            if (rd_req) nreads++;
            if (done) begin
                ndone++;
                // R8
                chk(res_valid && (res_idx == n_exp - 1), "R8 done with last result", res_idx, n_exp - 1);
            end
            if (res_valid && !prev_rv)
                // R7
                chk((cyc - last_rv) == 26, "R7 first result delay", cyc - last_rv, 26);
            if (res_valid) begin
                run++;
                // R4
                if (res_idx < n_exp)
                    chk($signed(res_data) == exp_y[res_idx], "R4 result value", $signed(res_data), exp_y[res_idx]);
                else
                    chk(1'b0, "R4 extra result", res_idx, n_exp);
                res_idx++;
            end else if (prev_rv) begin
                // R5
                chk(run == 4, "R5 burst length", run, 4);
                run = 0;
            end
            if (rd_valid) last_rv = cyc;
            prev_rv = res_valid;
        end
    end

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(signed'(16'(seed >> 16)));
    endfunction

    // mode 0 ramp, 1 random, 2 extreme negative, 3 impulse weight at 7
    task automatic setup(input int w, input int h, input int mode);
        for (int k = 0; k < 25; k++) begin
            case (mode)
                0: cf[k] = k - 12;
                1: cf[k] = rnd16();
                2: cf[k] = -32768;
                default: cf[k] = (k == 7) ? 1 : 0;
            endcase
        end
        for (int k = 0; k < w * h; k++) begin
            case (mode)
                0, 3: img[k] = k * 37 - 900;
                1: img[k] = rnd16();
                default: img[k] = -32768;
            endcase
        end
        for (int a = 0; a < 128; a++) mem[a] = '0;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                mem[ADDR_BASE + r * (w / 4) + c / 4][16 * (c % 4) +: 16] = 16'(img[r * w + c]);
        n_exp = 0;
        for (int i = 2; i <= h - 3; i++)
            for (int j = 2; j <= w - 3; j++) begin
                longint s = 0;
                for (int a = 0; a < 5; a++)
                    for (int b = 0; b < 5; b++)
                        s += longint'(cf[5 * a + b]) * longint'(img[(i + a - 2) * w + j + b - 2]);
                exp_y[n_exp] = s;
                n_exp++;
            end
        // R2 weight load, index 5a+b
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_idx = 5'(k); coef_data = 16'(cf[k]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic run_frame(input int w, input int h, input int lat_i, input bit disturb, input string tag);
        int wait_c = 0;
        lat = lat_i; img_w = DIM_W'(w); img_h = DIM_W'(h);
        res_idx = 0; nreads = 0; ndone = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            repeat (4) @(negedge clk);
            // R9 mid-frame start and weight write
            start = 1'b1; coef_we = 1'b1; coef_idx = 5'd12; coef_data = 16'h1234;
            @(negedge clk);
            start = 1'b0; coef_we = 1'b0;
        end
        while (ndone == 0 && wait_c < 30000) begin
            @(negedge clk); wait_c++;
        end
        repeat (60) @(negedge clk);
        chk(res_idx == n_exp, {tag, " R4 result count"}, res_idx, n_exp);
        chk(ndone == 1, {tag, " R8 done count"}, ndone, 1);
        // R3 R6 read count
        chk(nreads == (h - 4) * (10 + 5 * (w / 4 - 2)), {tag, " R6 read count"}, nreads, (h - 4) * (10 + 5 * (w / 4 - 2)));
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            // R1 during reset
            chk(!rd_req && !res_valid && !done, "R1 reset outputs", {rd_req, res_valid, done}, 0);
        end
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            // R1 idle after reset
            chk(!rd_req && !res_valid && !done, "R1 idle outputs", {rd_req, res_valid, done}, 0);
        end
        setup(8, 5, 0);   run_frame(8, 5, 1, 1'b0, "ramp8x5");
        setup(12, 7, 1);  run_frame(12, 7, 3, 1'b0, "rand12x7");
        setup(16, 6, 2);  run_frame(16, 6, 1, 1'b0, "extreme16x6");
        chk(exp_y[0] == 64'sd26843545600, "R4 full precision reference", exp_y[0], 64'sd26843545600);
        setup(12, 6, 3);  run_frame(12, 6, 2, 1'b0, "R2 impulse12x6");
        setup(16, 8, 1);  run_frame(16, 8, 2, 1'b1, "R9 disturb16x8");
        setup(8, 6, 0);   run_frame(8, 6, 4, 1'b0, "ramp8x6");
        finish_run();
    end
endmodule